// File: doc/BRIEF.md
# Parallel Test Vector Sequencer and Comparator

This block is the tester side of a parallel pin test. It holds an ordered list of vectors, set at elaboration time through a parameter, and plays them one after another onto a row of bidirectional probe pins. Each vector gives every pin a 3-bit symbol. The symbol says whether the tester drives the pin high or low, leaves it floating, compares it against an expected level, ignores it, treats it as a supply connection, or gives it one clock pulse in the middle of the period.

A single `start` pulse begins a run. Every vector occupies a fixed number of clock cycles. The pins coded as expectations are compared in the last cycle of the period, which comes after any mid-period clock pulse has ended. The first mismatch raises a sticky failure flag and keeps the vector index and the lowest failing pin number. After the final vector the block releases all pins and raises `done`. Both results hold until reset.

Top module: `pvec_tester`

## Requirements
- R1: Symbol code 0 drives its pin low and code 1 drives it high, with the pin's output enable held at 1 for every cycle of that vector's period.
- R2: Symbol codes 2 (float), 3 (ignore), 4 (expect low), 5 (expect high) and 6 (supply) leave the pin's output enable at 0 for the whole period.
- R3: Symbol code 7 enables the pin's output driver for the whole period. The pin is driven low in every phase except phase PERIOD/2, where it is driven high for exactly one cycle.
- R4: Only pins coded 4 or 5 are compared, against 0 and 1 respectively, using the pin input in phase PERIOD-1. The input value of a pin with any other code never causes a failure.
- R5: Vectors are applied in list order, starting with vector 0 at bit offset 0 of the parameter and pin i at bits [3i+2:3i]. Vector 0 begins phase 0 in the cycle after `start` is accepted, and every vector lasts exactly PERIOD cycles.
- R6: On the first mismatch, `fail` rises one cycle after that vector's compare edge. `fail_vec` then shows the vector index and `fail_pin` shows the lowest mismatching pin. All three hold until reset, and later mismatches do not change them.
- R7: `done` rises in the cycle after the last vector's compare edge and holds until reset. While `done` is high, all output enables are 0.
- R8: After reset, `busy`, `done`, `fail` and every output enable are 0. `start` is ignored while a run is in progress and after `done` has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle and not done |
| pin_in | input | NPINS | Level seen on each probe pin |
| pin_out | output | NPINS | Level driven onto each probe pin |
| pin_oe | output | NPINS | Per-pin output enable (1 = tester drives) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | All vectors have been applied |
| fail | output | 1 | A mismatch has been found |
| fail_vec | output | clog2(NVEC) | Index of the first failing vector |
| fail_pin | output | clog2(NPINS) | Lowest failing pin in that vector |

## Verification
With `start` accepted at clock edge E, vector v occupies the cycles after edges E+4v to E+4v+3 (with PERIOD = 4). Its drive levels and enables can therefore be read in those cycles, and its clock pin is high only after edge E+4v+2. A mismatch in vector v shows on `fail` from edge E+4v+4, and `done` appears after edge E+4·NVEC. The bench counts falling edges from the start edge so that each output is read in the exact cycle it becomes due. Where the timing matters, it also reads the cycle just before and expects the old value there.

// File: rtl/pvec_pkg.sv
// Package: symbol codes shared by the vector tester and its parts.
// Assumes 3-bit symbols; every code value is assigned a meaning.
package pvec_pkg;

    typedef enum logic [2:0] {
        SYM_DRV0  = 3'd0,
        SYM_DRV1  = 3'd1,
        SYM_FLOAT = 3'd2,
        SYM_DONTC = 3'd3,
        SYM_EXPL  = 3'd4,
        SYM_EXPH  = 3'd5,
        SYM_SUPPLY = 3'd6,
        SYM_CLKP  = 3'd7
    } sym_t;

    localparam int SYM_W = 3;

endpackage

// File: rtl/pvec_sequencer.sv
// Module: steps the phase counter within a vector period and the vector
// index through the list. Assumes PERIOD >= 4 and NVEC >= 2.
module pvec_sequencer #(
    parameter int NVEC   = 4,
    parameter int PERIOD = 4,
    localparam int VW    = $clog2(NVEC),
    localparam int PHW   = $clog2(PERIOD)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           run,
    output logic [PHW-1:0] phase,
    output logic [VW-1:0]  vec_idx,
    output logic           done,
    output logic           sample_en
);

    localparam logic [PHW-1:0] PH_LAST  = PHW'(PERIOD - 1);
    localparam logic [VW-1:0]  VEC_LAST = VW'(NVEC - 1);

    // Run control: accept start, advance phase and index, finish after last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            phase   <= '0;
            vec_idx <= '0;
            done    <= 1'b0;
        end else if (!run && !done && start) begin
            run     <= 1'b1;
            phase   <= '0;
            vec_idx <= '0;
        end else if (run) begin
            if (phase == PH_LAST) begin
                phase <= '0;
                if (vec_idx == VEC_LAST) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    vec_idx <= vec_idx + 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Compare strobe: last phase of every applied vector.
    assign sample_en = run && (phase == PH_LAST);

endmodule

// File: rtl/pvec_pin_lane.sv
// Module: decodes one pin's symbol into drive level, output enable and
// compare request. Assumes the clock pulse phase lies before the last phase.
module pvec_pin_lane
    import pvec_pkg::*;
#(
    parameter int PERIOD = 4,
    localparam int PHW   = $clog2(PERIOD),
    localparam logic [PHW-1:0] PH_PULSE = PHW'(PERIOD / 2)
) (
    input  logic [SYM_W-1:0] code,
    input  logic             run,
    input  logic [PHW-1:0]   phase,
    output logic             drv,
    output logic             oe,
    output logic             chk,
    output logic             expv
);

    // Symbol decode: all outputs quiet unless a run is in progress.
    always_comb begin
        drv  = 1'b0;
        oe   = 1'b0;
        chk  = 1'b0;
        expv = 1'b0;
        if (run) begin
            case (sym_t'(code))
                SYM_DRV0:  oe = 1'b1;
                SYM_DRV1:  begin oe = 1'b1; drv = 1'b1; end
                SYM_EXPL:  chk = 1'b1;
                SYM_EXPH:  begin chk = 1'b1; expv = 1'b1; end
                SYM_CLKP:  begin oe = 1'b1; drv = (phase == PH_PULSE); end
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/pvec_fail_latch.sv
// Module: forms the per-pin mismatch vector on the compare strobe and
// latches the first failure (vector index, lowest pin) until reset.
module pvec_fail_latch #(
    parameter int NVEC  = 4,
    parameter int NPINS = 8,
    localparam int VW   = $clog2(NVEC),
    localparam int PW   = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [NPINS-1:0] chk,
    input  logic [NPINS-1:0] expv,
    input  logic [NPINS-1:0] pin_in,
    input  logic [VW-1:0]    vec_idx,
    output logic             fail,
    output logic [VW-1:0]    fail_vec,
    output logic [PW-1:0]    fail_pin
);

    logic [NPINS-1:0] mism;
    logic [PW-1:0]    low_pin;

    // Mismatch on checked pins only.
    assign mism = chk & (pin_in ^ expv);

    // Lowest set mismatch bit wins.
    always_comb begin
        low_pin = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (mism[i]) low_pin = PW'(i);
        end
    end

    // First-failure capture, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail     <= 1'b0;
            fail_vec <= '0;
            fail_pin <= '0;
        end else if (sample_en && !fail && (|mism)) begin
            fail     <= 1'b1;
            fail_vec <= vec_idx;
            fail_pin <= low_pin;
        end
    end

endmodule

// File: rtl/pvec_tester.sv
// Module: parallel vector tester top. Vectors come from the VECTORS
// parameter: vector v at bits [v*NPINS*3 +: NPINS*3], pin i in 3 bits at i*3.
// Assumes PERIOD >= 4, NVEC >= 2, NPINS >= 2.
module pvec_tester
    import pvec_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int NVEC   = 4,
    parameter int PERIOD = 4,
    localparam int VW    = $clog2(NVEC),
    localparam int PW    = $clog2(NPINS),
    localparam int PHW   = $clog2(PERIOD),
    localparam int VBITS = NPINS * SYM_W,
    parameter logic [NVEC*VBITS-1:0] VECTORS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [VW-1:0]    fail_vec,
    output logic [PW-1:0]    fail_pin
);

    logic             run;
    logic [PHW-1:0]   phase;
    logic [VW-1:0]    vec_idx;
    logic             sample_en;
    logic [VBITS-1:0] cur_vec;
    logic [NPINS-1:0] chk;
    logic [NPINS-1:0] expv;

    pvec_sequencer #(.NVEC(NVEC), .PERIOD(PERIOD)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (run),
        .phase     (phase),
        .vec_idx   (vec_idx),
        .done      (done),
        .sample_en (sample_en)
    );

    // Vector store read: select the current vector from the preloaded list.
    assign cur_vec = VECTORS[vec_idx * VBITS +: VBITS];

    for (genvar g = 0; g < NPINS; g++) begin : g_lane
        pvec_pin_lane #(.PERIOD(PERIOD)) u_lane (
            .code  (cur_vec[g*SYM_W +: SYM_W]),
            .run   (run),
            .phase (phase),
            .drv   (pin_out[g]),
            .oe    (pin_oe[g]),
            .chk   (chk[g]),
            .expv  (expv[g])
        );
    end

    pvec_fail_latch #(.NVEC(NVEC), .NPINS(NPINS)) u_fail (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .chk       (chk),
        .expv      (expv),
        .pin_in    (pin_in),
        .vec_idx   (vec_idx),
        .fail      (fail),
        .fail_vec  (fail_vec),
        .fail_pin  (fail_pin)
    );

    assign busy = run;

endmodule

// File: rtl/pvec_tester_chk.sv
// Module: property checker bound to pvec_tester; observes ports and the
// sequencer state. Assumes synchronous active-low reset.
module pvec_tester_chk #(
    parameter int NPINS  = 8,
    parameter int NVEC   = 4,
    parameter int PERIOD = 4,
    localparam int VW    = $clog2(NVEC),
    localparam int PW    = $clog2(NPINS),
    localparam int PHW   = $clog2(PERIOD)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [PHW-1:0]   phase,
    input logic [VW-1:0]    vec_idx,
    input logic             done,
    input logic             fail,
    input logic [VW-1:0]    fail_vec,
    input logic [PW-1:0]    fail_pin,
    input logic [NPINS-1:0] pin_oe
);

    localparam logic [PHW-1:0] PH_LAST = PHW'(PERIOD - 1);

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pin_oe == '0));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_fail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (fail && $stable(fail_vec) && $stable(fail_pin)));

    p_fail_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (int'(fail_vec) <= NVEC - 1) && (int'(fail_pin) <= NPINS - 1));

    p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase != PH_LAST) |=> (phase == $past(phase) + 1'b1) && $stable(vec_idx));

    p_run_begin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (phase == '0) && (vec_idx == '0));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !run);

endmodule

bind pvec_tester pvec_tester_chk #(.NPINS(NPINS), .NVEC(NVEC), .PERIOD(PERIOD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .phase    (phase),
    .vec_idx  (vec_idx),
    .done     (done),
    .fail     (fail),
    .fail_vec (fail_vec),
    .fail_pin (fail_pin),
    .pin_oe   (pin_oe)
);

// File: tb/pvec_tester_bench.sv
// Bench: directed scenarios against a small device model (NAND on pin 4,
// OR on pin 6, junk on pin 5, supply on pin 7) with stuck-at injection.
module pvec_tester_bench;

    localparam int NPINS = 8;
    localparam int NVEC  = 6;
    localparam int PERIOD = 4;
    localparam logic [2:0] C0 = 3'd0, C1 = 3'd1, CZ = 3'd2, CX = 3'd3,
                           CL = 3'd4, CH = 3'd5, CP = 3'd6, CC = 3'd7;
    // pin7 .. pin0
    localparam logic [23:0] V0 = {CP, CL, CX, CH, CC, CZ, C0, C0};
    localparam logic [23:0] V1 = {CP, CH, CX, CH, CC, CZ, C0, C1};
    localparam logic [23:0] V2 = {CP, CH, CX, CL, CC, CZ, C1, C1};
    localparam logic [23:0] V3 = {CP, CH, CX, CH, CC, CZ, C1, C0};
    localparam logic [23:0] V4 = {CP, CX, CX, CL, C0, C1, C1, C1};
    localparam logic [23:0] V5 = {CP, CL, CX, CX, C1, C0, C0, C0};
    localparam logic [NVEC*24-1:0] VLIST = {V5, V4, V3, V2, V1, V0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] pin_in;
    logic [7:0] pin_out, pin_oe;
    logic       busy, done, fail;
    logic [2:0] fail_vec;
    logic [2:0] fail_pin;

    logic junk = 1'b0;
    logic f4_en = 1'b0, f4_val = 1'b0, f6_en = 1'b0, f6_val = 1'b0;
    logic [7:0] dev;
    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) junk <= ~junk;

    // Device model seen on undriven pins.
    always_comb begin
        dev    = 8'h80;
        dev[4] = f4_en ? f4_val : ~(pin_out[0] & pin_out[1]);
        dev[5] = junk;
        dev[6] = f6_en ? f6_val : (pin_out[0] | pin_out[1]);
        for (int i = 0; i < 8; i++) pin_in[i] = pin_oe[i] ? pin_out[i] : dev[i];
    end

    pvec_tester #(.NPINS(NPINS), .NVEC(NVEC), .PERIOD(PERIOD), .VECTORS(VLIST)) u_pvec_tester (
        .clk(clk), .rst_n(rst_n), .start(start), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .busy(busy), .done(done),
        .fail(fail), .fail_vec(fail_vec), .fail_pin(fail_pin)
    );

    task automatic check(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        f4_en = 1'b0; f6_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Leaves the bench at the falling edge just after the start edge (n=0).
    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(busy, 0, "R8 busy after reset");
        check(done, 0, "R8 done after reset");
        check(fail, 0, "R8 fail after reset");
        check(pin_oe, 0, "R8 oe after reset");
    endtask

    task automatic t_pass_run();
        do_reset();
        kick();                                        // n=0, V0 phase 0
        check(busy, 1, "R5 busy after start");
        check(pin_oe[0], 1, "R1 pin0 enabled");
        check(pin_out[0], 0, "R1 pin0 low");
        check({pin_oe[7], pin_oe[6], pin_oe[5], pin_oe[4], pin_oe[2]}, 0, "R2 released pins V0");
        check(pin_oe[3], 1, "R3 clock pin enabled");
        check(pin_out[3], 0, "R3 clock low phase 0");
        step(1);                                       // n=1
        check(pin_out[3], 0, "R3 clock low phase 1");
        step(1);                                       // n=2
        check(pin_out[3], 1, "R3 clock high mid-period");
        step(1);                                       // n=3
        check(pin_out[3], 0, "R3 clock low at compare");
        step(1);                                       // n=4, V1
        check(pin_out[0], 1, "R5 V1 applied after 4 cycles");
        check(pin_out[1], 0, "R1 pin1 low in V1");
        step(12);                                      // n=16, V4
        check(pin_out[2], 1, "R1 pin2 high in V4");
        check(pin_oe[2], 1, "R1 pin2 enabled in V4");
        check(pin_out[3], 0, "R1 pin3 low in V4");
        step(2);                                       // n=18
        check(pin_out[3], 0, "R1 pin3 stays low mid V4");
        check(pin_oe[6], 0, "R2 ignore pin released");
        step(5);                                       // n=23
        check(pin_out[3], 1, "R1 pin3 high in V5");
        check(done, 0, "R7 done not before last compare");
        step(1);                                       // n=24
        check(done, 1, "R7 done after last vector");
        check(busy, 0, "R7 idle after last vector");
        check(pin_oe, 0, "R7 pins released when done");
        check(fail, 0, "R4 junk and supply pins never fail");
        kick();
        step(2);
        check(busy, 0, "R8 start ignored after done");
        check(done, 1, "R8 done held");
    endtask

    task automatic t_first_fail_v0();
        do_reset();
        f4_en = 1'b1; f4_val = 1'b0;
        f6_en = 1'b1; f6_val = 1'b1;
        kick();
        step(3);                                       // n=3
        check(fail, 0, "R6 fail not before compare edge");
        step(1);                                       // n=4
        check(fail, 1, "R6 fail after V0 compare");
        check(fail_vec, 0, "R6 fail_vec V0");
        check(fail_pin, 4, "R6 lowest failing pin");
        kick();                                        // start while running
        step(19);                                      // n=24
        check(done, 1, "R8 run not restarted by start");
    endtask

    task automatic t_later_fail();
        do_reset();
        f4_en = 1'b1; f4_val = 1'b1;
        kick();
        step(11);                                      // n=11
        check(fail, 0, "R4 H pins matched in V0 and V1");
        step(1);                                       // n=12
        check(fail, 1, "R6 fail on V2");
        check(fail_vec, 2, "R6 fail_vec V2");
        check(fail_pin, 4, "R6 fail_pin on V2");
        step(12);                                      // n=24
        check(fail_vec, 2, "R6 first failure held over V4");
        check(done, 1, "R7 done with failure");
    endtask

    task automatic t_expect_high_pin6();
        do_reset();
        f6_en = 1'b1; f6_val = 1'b0;
        kick();
        step(8);                                       // n=8
        check(fail, 1, "R4 H mismatch on pin6 in V1");
        check(fail_vec, 1, "R6 fail_vec V1");
        check(fail_pin, 6, "R6 fail_pin 6");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_pass_run();
        t_first_fail_v0();
        t_later_fail();
        t_expect_high_pin6();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule